// File: doc/BRIEF.md
# Event Counter with Longest-Run Tracking

This block is a 32-bit performance counter. It selects one line out of a vector of event inputs. It can apply a privilege filter or a source-master filter to that line, and it then either counts the cycles in which the filtered event is high or measures durations. In duration mode it keeps a running count and a peak register. The running count restarts each time the chosen level begins. The peak register keeps the longest run seen so far. Depending on a level bit, that run is either the time the event stayed asserted or the gap between assertions.

Software reaches the block through a small register port with two addresses: a value word and a configuration word. Reads return data one cycle after the request. When the clear-on-read option is set, a read of the value word also zeroes the counter and the peak register.

Top module: `evcnt_top`

## Requirements
- R1: After reset the value word and the low 18 configuration bits read as zero, and `bus_rvalid` is low.
- R2: When the enable bit (configuration bit 12) is 1 and the duration bit (bit 16) is 0, the counter adds one for each clock cycle in which the event selected by the ID field (bits 11:4, index into `evt_in`) is high after filtering. Other event lines have no effect. A new configuration applies from the cycle after its write.
- R3: The counter saturates at 0xFFFFFFFF.
- R4: With the enable bit at 0, events change neither the counter nor the peak register.
- R5: A write to the value word (`bus_sel`=0) loads the data into both the counter and the peak register. A read returns the peak when the duration bit is 1, and the live count otherwise.
- R6: With the duration bit at 1 and the level bit (bit 17) at 1, the peak holds the longest run of consecutive cycles in which the event was high. The peak never falls below the live count.
- R7: With the duration bit at 1 and the level bit at 0, the peak holds the longest run of consecutive cycles in which the event was low.
- R8: The mode field (bits 15:14) filters IDs 0x00 to 0x3A only. Value 01 passes an event only when `evt_super` is 1. Value 10 passes it only when `evt_super` is 0. Values 00 and 11 pass it in both cases. IDs from 0x3B upward are not filtered by mode.
- R9: For IDs 0x40 to 0x7F, when mode bit 15 is 1, an event counts only if `evt_src` equals the master field (bits 3:0).
- R10: With the clear-on-read bit (bit 13) at 1, a value-word read returns the pre-clear value, zeroes the counter and the peak, and drops any event in that same cycle.
- R11: A configuration read (`bus_sel`=1) returns the written bits 17:0, with the capability constant (default 0x2E71) in bits 31:18. `bus_rvalid` goes high exactly in the cycle after each read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_EVT | Event lines, one per ID |
| evt_super | input | 1 | Privilege of current events, 1 = supervisor |
| evt_src | input | 4 | Source master ID of current events |
| bus_sel | input | 1 | 0 = value word, 1 = configuration word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High the cycle after a read |

## Verification
The counting path is driven with runs of different lengths on the selected line and with activity on a neighbouring line. This separates correct selection from counting all events. The privilege and master filters are tried with matching and non-matching side inputs, on IDs just inside and just outside the filtered ranges (0x3A, 0x3B, 0x45, 0x7F). Duration mode gets run patterns whose longest run is not the last one. This shows that the peak is kept rather than the most recent run. Reading the same state with the duration bit cleared then exposes the live count. Clear-on-read is tested with an event landing in the read cycle, which tells a dropped event from a counted one.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  typedef struct packed {
    logic       el;
    logic       cd;
    logic [1:0] su;
    logic       cl;
    logic       en;
    logic [7:0] eid;
    logic [3:0] mst;
  } ctrl_t;

  localparam int          CTRL_W     = $bits(ctrl_t);
  localparam logic [7:0]  MODE_LAST  = 8'h3A;
  localparam logic [7:0]  SRC_FIRST  = 8'h40;
  localparam logic [7:0]  SRC_LAST   = 8'h7F;
endpackage

// File: rtl/evcnt_filter.sv
module evcnt_filter
  import evcnt_pkg::*;
#(
  parameter int NUM_EVT = 128
) (
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               evt_super,
  input  logic [3:0]         evt_src,
  input  ctrl_t              cfg,
  output logic               hit
);
  localparam int IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic raw, mode_ok, src_ok;

  always_comb begin
    raw = 1'b0;
    if (int'(cfg.eid) < NUM_EVT) raw = evt_in[cfg.eid[IW-1:0]];

    mode_ok = 1'b1;
    if (cfg.eid <= MODE_LAST) begin
      case (cfg.su)
        2'b01:   mode_ok = evt_super;
        2'b10:   mode_ok = ~evt_super;
        default: mode_ok = 1'b1;
      endcase
    end

    src_ok = 1'b1;
    if (cfg.eid >= SRC_FIRST && cfg.eid <= SRC_LAST && cfg.su[1])
      src_ok = (evt_src == cfg.mst);

    hit = raw & mode_ok & src_ok;
  end
endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cd,
  input  logic             el,
  input  logic             hit,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] peak
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, peak_q, cnt_inc, cnt_n, peak_n;
  logic             lvl, prev_q;

  always_comb begin
    lvl     = el ? hit : ~hit;
    cnt_inc = (&cnt_q) ? cnt_q : cnt_q + ONE;
    cnt_n   = cnt_q;
    if (en) begin
      if (!cd) begin
        if (hit) cnt_n = cnt_inc;
      end else if (lvl) begin
        cnt_n = prev_q ? cnt_inc : ONE;
      end
    end
    peak_n = (en && cd && cnt_n > peak_q) ? cnt_n : peak_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      peak_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (ld) begin
        cnt_q  <= ld_val;
        peak_q <= ld_val;
      end else if (clr) begin
        cnt_q  <= '0;
        peak_q <= '0;
      end else begin
        cnt_q  <= cnt_n;
        peak_q <= peak_n;
      end
    end
  end

  assign cnt  = cnt_q;
  assign peak = peak_q;
endmodule

// File: rtl/evcnt_regs.sv
module evcnt_regs
  import evcnt_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter logic [13:0]      CAP_BITS = 14'h2E71
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] peak,
  output ctrl_t             cfg,
  output logic              ld,
  output logic              clr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  ctrl_t             cfg_q;
  logic [DATA_W-1:0] rd_mux;

  assign ld  = wr & ~sel;
  assign clr = rd & ~sel & cfg_q.cl;

  always_comb begin
    if (sel) rd_mux = DATA_W'({CAP_BITS, cfg_q});
    else     rd_mux = cfg_q.cd ? peak : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (wr && sel) cfg_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
  import evcnt_pkg::*;
#(
  parameter int          NUM_EVT  = 128,
  parameter int          DATA_W   = 32,
  parameter logic [13:0] CAP_BITS = 14'h2E71
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               evt_super,
  input  logic [3:0]         evt_src,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid
);
  ctrl_t             cfg_w;
  logic              hit_w, ld_w, clr_w;
  logic [DATA_W-1:0] cnt_w, peak_w;

  evcnt_filter #(.NUM_EVT(NUM_EVT)) filt_i (
    .evt_in(evt_in), .evt_super(evt_super), .evt_src(evt_src),
    .cfg(cfg_w), .hit(hit_w)
  );

  evcnt_core #(.CNT_W(DATA_W)) core_i (
    .clk(clk), .rst(rst), .en(cfg_w.en), .cd(cfg_w.cd), .el(cfg_w.el),
    .hit(hit_w), .ld(ld_w), .ld_val(bus_wdata), .clr(clr_w),
    .cnt(cnt_w), .peak(peak_w)
  );

  evcnt_regs #(.DATA_W(DATA_W), .CAP_BITS(CAP_BITS)) regs_i (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cnt(cnt_w), .peak(peak_w), .cfg(cfg_w),
    .ld(ld_w), .clr(clr_w), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );
endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr,
  input logic              rd,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] peak,
  input logic              en,
  input logic              cd,
  input logic              cl,
  input logic              rvalid
);
  logic wr_val, clr_val;
  assign wr_val  = wr & ~sel;
  assign clr_val = rd & ~sel & cl;

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_val |=> (cnt == $past(wdata)) && (peak == $past(wdata)));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_val && !wr_val) |=> (cnt == '0) && (peak == '0));

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_val && !clr_val) |=> $stable(cnt) && $stable(peak));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ((&cnt) && en && !cd && !wr_val && !clr_val) |=> (&cnt));

  p_peak_ge_r6: assert property (@(posedge clk) disable iff (rst)
    (cd && $past(cd)) |-> (peak >= cnt));

  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);
endmodule

bind evcnt_top evcnt_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
  .wdata(bus_wdata), .cnt(cnt_w), .peak(peak_w), .en(cfg_w.en),
  .cd(cfg_w.cd), .cl(cfg_w.cl), .rvalid(bus_rvalid)
);

// File: tb/evcnt_top_tb_top.sv
module evcnt_top_tb_top;
  localparam int          NE  = 128;
  localparam logic [13:0] CAP = 14'h2E71;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt = '0;
  logic          sup = 1'b0;
  logic [3:0]    src = '0;
  logic          sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  evcnt_top dut_i (
    .clk(clk), .rst(rst), .evt_in(evt), .evt_super(sup), .evt_src(src),
    .bus_sel(sel), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata), .bus_rvalid(rvalid)
  );

  function automatic logic [31:0] mk(input logic en, input logic cl,
      input logic [1:0] su, input logic cd, input logic el,
      input logic [7:0] id, input logic [3:0] m);
    return {14'b0, el, cd, su, cl, en, id, m};
  endfunction

  task automatic wr_reg(input logic s, input logic [31:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input logic s, input logic [31:0] e, input string t);
    @(negedge clk); sel = s; rd = 1'b1; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic level(input int b, input logic v, input int n);
    @(negedge clk); evt[b] = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic pulse(input int b, input int n);
    level(b, 1'b1, n);
    level(b, 1'b0, 1);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rvalid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R11: unexpected read data 0x%08h, expected none", rdata);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string       t = tag_q.pop_front();
          if (rdata !== e) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", t, rdata, e);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rvalid got %b expected 0", rvalid);
    end
    rd_chk(1'b0, 32'h0, "R1 value after reset");
    rd_chk(1'b1, {CAP, 18'h0}, "R1 config after reset");

    // R2 plain counting, neighbour line ignored
    wr_reg(1'b1, mk(1, 0, 2'b00, 0, 0, 8'd5, 4'd0));
    pulse(5, 7);
    pulse(6, 3);
    rd_chk(1'b0, 32'd7, "R2 count selected line");

    // R4 disabled
    wr_reg(1'b1, mk(0, 0, 2'b00, 0, 0, 8'd5, 4'd0));
    pulse(5, 4);
    rd_chk(1'b0, 32'd7, "R4 disabled no change");

    // R5 load, R3 saturation
    wr_reg(1'b0, 32'hFFFF_FFFD);
    rd_chk(1'b0, 32'hFFFF_FFFD, "R5 loaded value");
    wr_reg(1'b1, mk(1, 0, 2'b00, 0, 0, 8'd5, 4'd0));
    pulse(5, 5);
    rd_chk(1'b0, 32'hFFFF_FFFF, "R3 saturate");

    // R8 privilege filter
    wr_reg(1'b1, mk(1, 0, 2'b01, 0, 0, 8'd5, 4'd0));
    wr_reg(1'b0, 32'h0);
    sup = 1'b0; pulse(5, 3);
    sup = 1'b1; pulse(5, 2);
    rd_chk(1'b0, 32'd2, "R8 supervisor only");
    wr_reg(1'b1, mk(1, 0, 2'b10, 0, 0, 8'd5, 4'd0));
    wr_reg(1'b0, 32'h0);
    sup = 1'b0; pulse(5, 3);
    sup = 1'b1; pulse(5, 4);
    rd_chk(1'b0, 32'd3, "R8 user only");
    wr_reg(1'b1, mk(1, 0, 2'b11, 0, 0, 8'd5, 4'd0));
    wr_reg(1'b0, 32'h0);
    sup = 1'b0; pulse(5, 2);
    sup = 1'b1; pulse(5, 2);
    rd_chk(1'b0, 32'd4, "R8 mode 11 counts all");
    wr_reg(1'b1, mk(1, 0, 2'b01, 0, 0, 8'h3A, 4'd0));
    wr_reg(1'b0, 32'h0);
    sup = 1'b0; pulse(8'h3A, 3);
    rd_chk(1'b0, 32'd0, "R8 id 0x3A filtered");
    wr_reg(1'b1, mk(1, 0, 2'b01, 0, 0, 8'h3B, 4'd0));
    wr_reg(1'b0, 32'h0);
    pulse(8'h3B, 2);
    rd_chk(1'b0, 32'd2, "R8 id 0x3B unfiltered");

    // R9 master filter
    wr_reg(1'b1, mk(1, 0, 2'b10, 0, 0, 8'h45, 4'd3));
    wr_reg(1'b0, 32'h0);
    src = 4'd3; pulse(8'h45, 2);
    src = 4'd7; pulse(8'h45, 5);
    rd_chk(1'b0, 32'd2, "R9 master match");
    wr_reg(1'b1, mk(1, 0, 2'b11, 0, 0, 8'h7F, 4'd9));
    wr_reg(1'b0, 32'h0);
    src = 4'd9; pulse(8'h7F, 1);
    src = 4'd2; pulse(8'h7F, 3);
    rd_chk(1'b0, 32'd1, "R9 id 0x7F match");
    wr_reg(1'b1, mk(1, 0, 2'b01, 0, 0, 8'h45, 4'd3));
    wr_reg(1'b0, 32'h0);
    src = 4'd7; pulse(8'h45, 3);
    rd_chk(1'b0, 32'd3, "R9 no master filter");

    // R6 longest asserted run
    sup = 1'b0; src = 4'd0;
    wr_reg(1'b1, mk(1, 0, 2'b00, 1, 1, 8'd5, 4'd0));
    wr_reg(1'b0, 32'h0);
    level(5, 1'b1, 3); level(5, 1'b0, 2);
    level(5, 1'b1, 5); level(5, 1'b0, 2);
    level(5, 1'b1, 2); level(5, 1'b0, 1);
    rd_chk(1'b0, 32'd5, "R6 peak asserted run");
    wr_reg(1'b1, mk(1, 0, 2'b00, 0, 1, 8'd5, 4'd0));
    rd_chk(1'b0, 32'd2, "R5 live count shown");

    // R7 longest gap
    level(5, 1'b1, 1);
    wr_reg(1'b1, mk(1, 0, 2'b00, 1, 0, 8'd5, 4'd0));
    wr_reg(1'b0, 32'h0);
    level(5, 1'b0, 4); level(5, 1'b1, 2);
    level(5, 1'b0, 6); level(5, 1'b1, 1);
    level(5, 1'b0, 3); level(5, 1'b1, 1);
    rd_chk(1'b0, 32'd6, "R7 peak gap");
    level(5, 1'b0, 1);

    // R10 clear on read
    wr_reg(1'b1, mk(1, 1, 2'b00, 0, 0, 8'd5, 4'd0));
    wr_reg(1'b0, 32'h0);
    pulse(5, 4);
    @(negedge clk); evt[5] = 1'b1; sel = 1'b0; rd = 1'b1;
    exp_q.push_back(32'd4); tag_q.push_back("R10 pre-clear value");
    @(negedge clk); rd = 1'b0; evt[5] = 1'b0;
    rd_chk(1'b0, 32'd0, "R10 cleared, event dropped");
    wr_reg(1'b0, 32'd9);
    rd_chk(1'b0, 32'd9, "R10 read before clear");
    wr_reg(1'b1, mk(1, 0, 2'b00, 1, 1, 8'd5, 4'd0));
    rd_chk(1'b0, 32'd0, "R10 peak cleared");

    // R11 configuration readback
    wr_reg(1'b1, 32'h0003_ABCD);
    rd_chk(1'b1, {CAP, 18'h3ABCD}, "R11 config readback");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule